// File: doc/BRIEF.md
# Ultrasonic Time-of-Flight Ranger

This block runs one ultrasonic range measurement per start command. It drives the transducer with a short square-wave burst at the tone frequency, which it derives from the system clock. It counts clock cycles from the cycle the burst begins. It stops at the first received sample, taken after a blanking window, whose amplitude lies strictly above a programmable threshold. The elapsed count is converted to millimetres by a fixed-point multiply and shift. The result is presented with a single-cycle valid pulse.

The blanking window keeps transmitter ringing from being mistaken for an echo. If no echo arrives before a maximum count, the measurement ends with a single-cycle timeout pulse and no distance. A start command that arrives while a measurement runs has no effect. The echo input carries digitized samples from an external front end.

Top module: `tof_ranger`

## Requirements
- R1: After reset, txDrive, distValid and timeout are all 0.
- R2: The burst is HALF = CLK_HZ/(2*TONE_HZ) cycles high, then HALF cycles low, repeated burstLen times, with a burstLen of 0 treated as 1. Observed after the accepted start edge (edge 0) and after each edge j that follows, txDrive is 1 exactly when j < 2*burstLen*HALF and floor(j/HALF) is even.
- R3: The tick count of an echo seen at the k-th rising edge after the start edge is k.
- R4: A sample counts as an echo only when echoAmp > threshold, compared as unsigned numbers. A sample equal to the threshold does not count.
- R5: Samples at edges k < 2*burstLen*HALF + BLANK_TICKS are ignored, whatever their amplitude.
- R6: Only the first qualifying sample ends the measurement. Later crossings in the same measurement produce no further distValid.
- R7: distMm = (k*KMUL) >> SHIFT, where KMUL = round(170000 * 2^SHIFT / CLK_HZ). This is 340 m/s times the round-trip time, halved, in mm.
- R8: If no echo is accepted at any edge k < MAX_TICKS, timeout pulses for one cycle after edge MAX_TICKS and distValid stays 0.
- R9: A start command sampled while a measurement runs is ignored. The count and the result are unchanged.
- R10: distValid is high for exactly one cycle, after the edge that accepts the echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a measurement |
| burstLen | input | BL_W | Number of tone periods in the burst |
| echoAmp | input | AMP_W | Digitized received amplitude |
| threshold | input | AMP_W | Detection level |
| txDrive | output | 1 | Transducer square-wave drive |
| distMm | output | DIST_W | Measured distance in millimetres |
| distValid | output | 1 | One-cycle pulse when distMm is new |
| timeout | output | 1 | One-cycle pulse when no echo was found |

## Verification
The bench places echoes inside the blanking window and checks that the reported tick is the window end. A design that listened too early would instead report ringing as a near target. It drives an amplitude exactly equal to the threshold, which an off-by-one compare would accept, and an echo on the last listening tick, which a counter bound that is off by one would report as a timeout. It also sends a second crossing and a mid-measurement start; a design that got these wrong would emit a second result or restart its count. A burst length of zero is exercised to catch a burst that underflows and never ends.

// File: rtl/tof_pkg.sv
package tof_pkg;
  typedef struct packed {
    logic clear;    // begin a measurement
    logic count;    // advance tick counter
    logic capture;  // latch distance
    logic expire;   // report timeout
  } tofStrobeT;
endpackage

// File: rtl/tof_ctrl.sv
module tof_ctrl
  import tof_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      hit,
  input  logic      atMax,
  output tofStrobeT strb,
  output logic      running
);
  typedef enum logic {S_IDLE, S_RUN} stateT;
  stateT state;

  always_comb begin
    strb = '0;
    if (state == S_IDLE) begin
      strb.clear = startReq;
    end else begin
      strb.count   = 1'b1;
      strb.capture = hit;
      strb.expire  = !hit && atMax;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else if (state == S_IDLE && startReq) state <= S_RUN;
    else if (state == S_RUN && (hit || atMax)) state <= S_IDLE;
  end

  assign running = (state == S_RUN);

  // R4/R8: capture and expire never fire together
  p_one_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capture && strb.expire));
endmodule

// File: rtl/tof_datapath.sv
module tof_datapath
  import tof_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int TONE_HZ     = 40_000,
  parameter int BL_W        = 4,
  parameter int AMP_W       = 8,
  parameter int DIST_W      = 16,
  parameter int BLANK_TICKS = 50_000,
  parameter int MAX_TICKS   = 2_000_000,
  parameter int SHIFT       = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  tofStrobeT         strb,
  input  logic [BL_W-1:0]   burstLen,
  input  logic [AMP_W-1:0]  echoAmp,
  input  logic [AMP_W-1:0]  threshold,
  output logic              hit,
  output logic              atMax,
  output logic              txDrive,
  output logic [DIST_W-1:0] distMm,
  output logic              distValid,
  output logic              timeout
);
  localparam int HALF  = CLK_HZ / (2 * TONE_HZ);
  localparam int PH_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CW    = $clog2(MAX_TICKS + 2);
  localparam int HL_W  = BL_W + 1;
  localparam longint unsigned KMUL_L =
    ((64'd170000 << SHIFT) + 64'(CLK_HZ / 2)) / 64'(CLK_HZ);
  localparam logic [31:0] KMUL = 32'(KMUL_L);

  logic [CW-1:0]   cnt;
  logic [PH_W-1:0] phase;
  logic [HL_W-1:0] halvesLeft;
  logic            burstOn, level;
  logic [BL_W-1:0] burstEff;
  logic [31:0]     listenStart;
  logic [63:0]     prod;

  assign burstEff    = (burstLen == '0) ? BL_W'(1) : burstLen;
  assign listenStart = 32'(burstEff) * 32'(2 * HALF) + 32'(BLANK_TICKS);
  assign atMax       = (32'(cnt) == 32'(MAX_TICKS));
  assign hit         = strb.count && (32'(cnt) >= listenStart) &&
                       (32'(cnt) < 32'(MAX_TICKS)) && (echoAmp > threshold);
  assign prod        = 64'(cnt) * 64'(KMUL);
  assign txDrive     = burstOn && level;

  // tick counter
  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (strb.clear) cnt <= CW'(1);
    else if (strb.count) cnt <= cnt + CW'(1);
  end

  // tone generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstOn <= 1'b0; level <= 1'b0; phase <= '0; halvesLeft <= '0;
    end else if (strb.clear) begin
      burstOn    <= 1'b1;
      level      <= 1'b1;
      phase      <= '0;
      halvesLeft <= {burstEff, 1'b0} - HL_W'(1);
    end else if (burstOn) begin
      if (32'(phase) == 32'(HALF - 1)) begin
        phase <= '0;
        if (halvesLeft == '0) begin
          burstOn <= 1'b0;
          level   <= 1'b0;
        end else begin
          level      <= ~level;
          halvesLeft <= halvesLeft - HL_W'(1);
        end
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      distMm <= '0; distValid <= 1'b0; timeout <= 1'b0;
    end else begin
      distValid <= strb.capture;
      timeout   <= strb.expire;
      if (strb.capture) distMm <= DIST_W'(prod >> SHIFT);
    end
  end

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    distValid |=> !distValid);
  p_blank_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (32'(cnt) >= listenStart));
  p_count_grows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.count && !strb.clear && !atMax) |=> (cnt > $past(cnt)));
endmodule

// File: rtl/tof_ranger.sv
module tof_ranger
  import tof_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int TONE_HZ     = 40_000,
  parameter int BL_W        = 4,
  parameter int AMP_W       = 8,
  parameter int DIST_W      = 16,
  parameter int BLANK_TICKS = 50_000,
  parameter int MAX_TICKS   = 2_000_000,
  parameter int SHIFT       = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [BL_W-1:0]   burstLen,
  input  logic [AMP_W-1:0]  echoAmp,
  input  logic [AMP_W-1:0]  threshold,
  output logic              txDrive,
  output logic [DIST_W-1:0] distMm,
  output logic              distValid,
  output logic              timeout
);
  tofStrobeT strb;
  logic hit, atMax, running;

  tof_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .hit(hit), .atMax(atMax),
    .strb(strb), .running(running)
  );

  tof_datapath #(
    .CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .BL_W(BL_W), .AMP_W(AMP_W),
    .DIST_W(DIST_W), .BLANK_TICKS(BLANK_TICKS), .MAX_TICKS(MAX_TICKS),
    .SHIFT(SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .burstLen(burstLen),
    .echoAmp(echoAmp), .threshold(threshold), .hit(hit), .atMax(atMax),
    .txDrive(txDrive), .distMm(distMm), .distValid(distValid),
    .timeout(timeout)
  );

  p_result_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(distValid && timeout));
  p_tx_only_running_r2: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !txDrive);
  p_run_ends_with_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    running |=> (running || distValid || timeout));
endmodule

// File: tb/tb_tof_ranger.sv
module tb_tof_ranger;
  localparam int CLK_HZ = 400_000, TONE_HZ = 40_000, HALF = 5;
  localparam int BLANK = 6, MAXT = 300, SH = 16;
  localparam longint KMUL = ((64'd170000 << SH) + CLK_HZ/2) / CLK_HZ;

  logic clk = 0, rstN = 0, startReq = 0;
  logic [3:0] burstLen = 0;
  logic [7:0] echoAmp = 0, threshold = 0;
  logic txDrive, distValid, timeout;
  logic [15:0] distMm;

  int checks = 0, errors = 0;

  tof_ranger #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .BLANK_TICKS(BLANK),
    .MAX_TICKS(MAXT), .SHIFT(SH)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burstLen(burstLen),
    .echoAmp(echoAmp), .threshold(threshold), .txDrive(txDrive),
    .distMm(distMm), .distValid(distValid), .timeout(timeout));

  always #5 clk = ~clk;

  // vector: burst[35:32] thr[31:24] echoAt[23:8] amp[7:0]
  localparam logic [35:0] VEC [8] = '{
    {4'd8,  8'd100, 16'd120, 8'd200},
    {4'd1,  8'd50,  16'd30,  8'd60},
    {4'd8,  8'd100, 16'd40,  8'd200},
    {4'd2,  8'd128, 16'd100, 8'd128},
    {4'd2,  8'd128, 16'd100, 8'd129},
    {4'd15, 8'd30,  16'd299, 8'd255},
    {4'd0,  8'd30,  16'd5,   8'd255},
    {4'd3,  8'd80,  16'd300, 8'd255}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one measurement; dip: echo falls then rises again; restartAt: extra start
  task automatic measure(input int b, input int thr, input int echoAt, input int amp,
                         input bit dip, input int restartAt, input string tag);
    int beff, ls, expK, validAt, validCnt, toAt, txErr, dval;
    bit expTo;
    beff = (b == 0) ? 1 : b;
    ls = 2 * beff * HALF + BLANK;
    expK = (echoAt > ls) ? echoAt : ls;
    expTo = !(amp > thr) || (expK >= MAXT);
    validAt = -1; validCnt = 0; toAt = -1; txErr = 0; dval = 0;
    burstLen = 4'(b); threshold = 8'(thr);
    for (int j = 0; j < MAXT + 20; j++) begin
      startReq = (j == 0) || (j == restartAt);
      if (j >= echoAt && !(dip && j >= echoAt + 2 && j < echoAt + 4)) echoAmp = 8'(amp);
      else echoAmp = 8'd10;
      @(negedge clk);
      if (txDrive !== ((j < 2 * beff * HALF) && ((j / HALF) % 2 == 0))) txErr++;
      if (distValid) begin
        validCnt++;
        if (validAt < 0) begin validAt = j; dval = int'(distMm); end
      end
      if (timeout && toAt < 0) toAt = j;
    end
    startReq = 0; echoAmp = 0;
    check(txErr == 0, {"R2 tx burst ", tag}, txErr, 0);
    if (expTo) begin
      check(toAt == MAXT, {"R8 timeout tick ", tag}, toAt, MAXT);
      check(validCnt == 0, {"R8 no distance ", tag}, validCnt, 0);
    end else begin
      check(validAt == expK, {"R3/R4/R5 echo tick ", tag}, validAt, expK);
      check(dval == int'((longint'(expK) * KMUL) >> SH), {"R7 distance ", tag},
            dval, int'((longint'(expK) * KMUL) >> SH));
      check(validCnt == 1, {"R6/R10 single valid ", tag}, validCnt, 1);
      check(toAt < 0, {"R8 no timeout on hit ", tag}, toAt, -1);
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txDrive == 0 && distValid == 0 && timeout == 0, "R1 reset outputs",
          {txDrive, distValid, timeout}, 0);
    rstN = 1;
    @(negedge clk);
    for (int v = 0; v < 8; v++)
      measure(int'(VEC[v][35:32]), int'(VEC[v][31:24]), int'(VEC[v][23:8]),
              int'(VEC[v][7:0]), 1'b0, -1, $sformatf("vec%0d", v));
    // R6 second crossing after a dip
    measure(8, 100, 120, 200, 1'b1, -1, "dip R6");
    // R9 start ignored mid-measurement
    measure(8, 100, 150, 200, 1'b0, 40, "restart R9");
    // R7 sanity against exact conversion (0.425 mm per tick here)
    check(int'((longint'(200) * KMUL) >> SH) == 85, "R7 scale", 
          int'((longint'(200) * KMUL) >> SH), 85);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule